// File: doc/BRIEF.md
# Vectored interrupt request controller

This block sits between seven peripheral interrupt sources and a CPU whose bus uses an address strobe and a function-code field. It samples the seven active-low request lines on every clock. It reduces them to a 3-bit active-low priority level, so the CPU sees only the most urgent pending level.

When the CPU runs an interrupt-acknowledge bus cycle, the block decodes that cycle into one of seven active-low per-level acknowledge strobes. It then answers the cycle itself. It drives the vector byte held for the serviced level and asserts the data-transfer acknowledge. It releases both when the address strobe goes away. The CPU-side comparison against its interrupt mask is not part of this block.

The answering logic is a two-state machine:
- `ST_IDLE` is the state after reset. Nothing is driven and the transfer acknowledge is high.
- `ST_IDLE -> ST_DRIVE` is taken on a clock edge where a valid acknowledge is decoded. The serviced level is latched on that edge.
- In `ST_DRIVE` the latched level's vector byte is on the bus and the transfer acknowledge is low, while the address strobe stays low.
- `ST_DRIVE -> ST_IDLE` is taken on the first clock edge that sees the address strobe high.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `ipl_n` is 3'b111, all `iack_n` bits are 1, `dtack_n` is 1, `vec_oe` is 0 and `vec_out` is 0.
- R2: `irq_n` bit k carries the request for level k+1, and the request is active when the bit is 0. One clock edge after the request lines change, `ipl_n` equals the bitwise inverse of the highest active level. With no request active, the level is 0 and `ipl_n` is 3'b111.
- R3: When several request lines are active together, only the highest level among them appears on `ipl_n`. Lower requests have no effect on it.
- R4: An active level-7 request (`irq_n` bit 6 low) always gives `ipl_n` = 3'b000, whatever the other lines do.
- R5: `iack_n` bit k-1 is 0 exactly while `as_n` is 0, `fc` is 3'b111 and `addr_lvl` is k, for k from 1 to 7. At most one `iack_n` bit is ever 0.
- R6: All `iack_n` bits are 1 in each of these cases: `as_n` is 1; `fc` is any other code (3'b001 user data, 3'b010 user program, 3'b101 supervisor data, 3'b110 supervisor program, or an unused code); or `addr_lvl` is 0.
- R7: On the first clock edge after a valid acknowledge is decoded while idle, `dtack_n` goes to 0 and `vec_oe` goes to 1. At the same time, `vec_out` shows byte k-1 of `vec_table`, which is bits [8k-1:8k-8], for serviced level k. Before that edge `dtack_n` is 1.
- R8: While `as_n` is 1, `dtack_n` is 1, `vec_oe` is 0 and `vec_out` is 0. The release takes effect in the same cycle that `as_n` rises.
- R9: The serviced level is latched when the answer starts. A change of `addr_lvl` while `as_n` stays low does not change `vec_out`. A new acknowledge is only taken after `as_n` has been seen high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 7 | Active-low requests, bit k = level k+1 |
| fc | input | 3 | CPU function code of the current bus cycle |
| addr_lvl | input | 3 | Low address bits carrying the serviced level |
| as_n | input | 1 | Active-low address strobe |
| vec_table | input | 56 | Vector bytes, byte k-1 for level k |
| ipl_n | output | 3 | Active-low encoded priority level |
| iack_n | output | 7 | Active-low per-level acknowledge strobes |
| vec_out | output | 8 | Vector byte for the low data lines |
| vec_oe | output | 1 | Drive enable for `vec_out` |
| dtack_n | output | 1 | Active-low data-transfer acknowledge |

## Verification
The assertions take for granted that the CPU negates the address strobe between two bus cycles. They also assume that the function code and low address bits are stable at each clock edge. The bench changes all inputs only on falling clock edges and raises `as_n` after every directed acknowledge. Random function-code and level mixes are run first, and two idle cycles with the strobe high follow them, so the directed answers always start from `ST_IDLE`.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int NLEVEL   = 7;
    localparam int LVLW     = $clog2(NLEVEL + 1);
    localparam int VECW     = 8;
    localparam int FCW      = 3;
    localparam logic [FCW-1:0] FC_INTACK = 3'b111;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DRIVE = 1'b1
    } ans_state_t;
endpackage

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc
    import irqv_pkg::*;
#(
    parameter int NL = NLEVEL,
    parameter int LW = LVLW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] irq_n,
    output logic [LW-1:0] ipl_n
);
    logic [NL-1:0] req_q;
    logic [LW-1:0] top_lvl;

    // one sampling flop per request line
    for (genvar g = 0; g < NL; g++) begin : g_req
        always_ff @(posedge clk) begin
            if (!rst_n) req_q[g] <= 1'b0;
            else        req_q[g] <= ~irq_n[g];
        end
    end

    // scan upwards so the highest active level ends up in top_lvl
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < NL; i++) begin
            if (req_q[i]) top_lvl = LW'(i + 1);
        end
    end

    assign ipl_n = ~top_lvl;

    AST_TOP_LEVEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        req_q[NL-1] |-> (ipl_n == '0)); // R4
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q == '0) |-> (&ipl_n)); // R2
endmodule

// File: rtl/irqv_ack_decode.sv
module irqv_ack_decode
    import irqv_pkg::*;
#(
    parameter int NL = NLEVEL,
    parameter int LW = LVLW,
    parameter int FW = FCW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] fc,
    input  logic [LW-1:0] addr_lvl,
    input  logic          as_n,
    output logic          ack_hit,
    output logic [NL-1:0] iack_n
);
    logic cycle_is_ack;

    assign cycle_is_ack = !as_n && (fc == FC_INTACK);
    assign ack_hit      = cycle_is_ack && (addr_lvl != '0);

    for (genvar g = 0; g < NL; g++) begin : g_strobe
        assign iack_n[g] = ~(cycle_is_ack && (addr_lvl == LW'(g + 1)));
    end

    AST_IACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~iack_n)); // R5
    AST_IACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (as_n || fc != FC_INTACK) |-> (&iack_n)); // R6
endmodule

// File: rtl/irqv_answer_fsm.sv
module irqv_answer_fsm
    import irqv_pkg::*;
#(
    parameter int NL = NLEVEL,
    parameter int LW = LVLW,
    parameter int VW = VECW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_hit,
    input  logic             as_n,
    input  logic [LW-1:0]    addr_lvl,
    input  logic [NL*VW-1:0] vec_table,
    output logic [VW-1:0]    vec_out,
    output logic             vec_oe,
    output logic             dtack_n
);
    ans_state_t    st_q, st_d;
    logic [LW-1:0] lvl_q;
    logic [VW-1:0] sel_vec;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (ack_hit) st_d = ST_DRIVE;
            ST_DRIVE: if (as_n)    st_d = ST_IDLE;
            default:               st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            lvl_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && ack_hit) lvl_q <= addr_lvl;
        end
    end

    always_comb begin
        sel_vec = '0;
        for (int i = 0; i < NL; i++) begin
            if (lvl_q == LW'(i + 1)) sel_vec = vec_table[i*VW +: VW];
        end
    end

    always_comb begin
        vec_oe  = 1'b0;
        dtack_n = 1'b1;
        vec_out = '0;
        unique case (st_q)
            ST_IDLE: ;
            ST_DRIVE: begin
                if (!as_n) begin
                    vec_oe  = 1'b1;
                    dtack_n = 1'b0;
                    vec_out = sel_vec;
                end
            end
            default: ;
        endcase
    end

    AST_ANSWER_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && ack_hit) |=> (as_n || (!dtack_n && vec_oe))); // R7
    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRIVE && !as_n) |=> $stable(lvl_q)); // R9
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLEVEL-1:0]    irq_n,
    input  logic [FCW-1:0]       fc,
    input  logic [LVLW-1:0]      addr_lvl,
    input  logic                 as_n,
    input  logic [NLEVEL*VECW-1:0] vec_table,
    output logic [LVLW-1:0]      ipl_n,
    output logic [NLEVEL-1:0]    iack_n,
    output logic [VECW-1:0]      vec_out,
    output logic                 vec_oe,
    output logic                 dtack_n
);
    logic ack_hit;

    irqv_prio_enc #(.NL(NLEVEL), .LW(LVLW)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_n (irq_n),
        .ipl_n (ipl_n)
    );

    irqv_ack_decode #(.NL(NLEVEL), .LW(LVLW), .FW(FCW)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .fc       (fc),
        .addr_lvl (addr_lvl),
        .as_n     (as_n),
        .ack_hit  (ack_hit),
        .iack_n   (iack_n)
    );

    irqv_answer_fsm #(.NL(NLEVEL), .LW(LVLW), .VW(VECW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_hit   (ack_hit),
        .as_n      (as_n),
        .addr_lvl  (addr_lvl),
        .vec_table (vec_table),
        .vec_out   (vec_out),
        .vec_oe    (vec_oe),
        .dtack_n   (dtack_n)
    );

    AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (dtack_n && !vec_oe)); // R8
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  irq_n;
    logic [2:0]  fc;
    logic [2:0]  addr_lvl;
    logic        as_n;
    logic [55:0] vec_table;
    logic [2:0]  ipl_n;
    logic [6:0]  iack_n;
    logic [7:0]  vec_out;
    logic        vec_oe;
    logic        dtack_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .fc(fc), .addr_lvl(addr_lvl),
        .as_n(as_n), .vec_table(vec_table), .ipl_n(ipl_n), .iack_n(iack_n),
        .vec_out(vec_out), .vec_oe(vec_oe), .dtack_n(dtack_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_ipl(input logic [6:0] lines);
        logic [2:0] lvl = 3'd0;
        for (int i = 0; i < 7; i++) if (!lines[i]) lvl = 3'(i + 1);
        return ~lvl;
    endfunction

    function automatic logic [6:0] exp_iack(input logic s_n, input logic [2:0] f, input logic [2:0] l);
        logic [6:0] r = 7'h7F;
        if (!s_n && f == 3'b111 && l != 3'd0) r[l-1] = 1'b0;
        return r;
    endfunction

    function automatic logic [7:0] exp_vec(input logic [2:0] l);
        return vec_table[(int'(l) - 1)*8 +: 8];
    endfunction

    task automatic drive_irq(input logic [6:0] v, input string req);
        @(negedge clk); irq_n = v;
        @(posedge clk); #1;
        check(req, 32'(ipl_n), 32'(exp_ipl(v)));
    endtask

    task automatic do_ack(input logic [2:0] l);
        @(negedge clk); fc = 3'b111; addr_lvl = l; as_n = 1'b0;
        #1;
        check("R5", 32'(iack_n), 32'(exp_iack(1'b0, 3'b111, l)));
        check("R7 before edge", 32'(dtack_n), 32'd1);
        @(posedge clk); #1;
        check("R7 dtack", 32'(dtack_n), 32'd0);
        check("R7 oe", 32'(vec_oe), 32'd1);
        check("R7 vector", 32'(vec_out), 32'(exp_vec(l)));
        @(negedge clk); addr_lvl = (l == 3'd7) ? 3'd1 : l + 3'd1;
        @(posedge clk); #1;
        check("R9 latched", 32'(vec_out), 32'(exp_vec(l)));
        @(negedge clk); as_n = 1'b1; #1;
        check("R8 dtack", 32'(dtack_n), 32'd1);
        check("R8 oe", 32'(vec_oe), 32'd0);
        check("R8 vec", 32'(vec_out), 32'd0);
        @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst_n = 1'b0; irq_n = 7'h7F; fc = 3'b001; addr_lvl = 3'd0; as_n = 1'b1;
        vec_table = {$urandom(), $urandom()};
        repeat (3) @(posedge clk);
        #1;
        check("R1 ipl", 32'(ipl_n), 32'h7);
        check("R1 iack", 32'(iack_n), 32'h7F);
        check("R1 dtack", 32'(dtack_n), 32'd1);
        check("R1 oe", 32'(vec_oe), 32'd0);
        check("R1 vec", 32'(vec_out), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // directed priority corners
        drive_irq(7'h7F, "R2 none");
        drive_irq(7'h7E, "R2 level1");
        drive_irq(7'h3F, "R4 level7 alone");
        drive_irq(7'h00, "R4 all active");
        drive_irq(7'h6A, "R3 mixed");
        drive_irq(7'h3C, "R4 level7 with others");

        // random request patterns
        for (int n = 0; n < 300; n++) begin
            logic [6:0] v = 7'($urandom());
            drive_irq(v, (v[6] == 1'b0) ? "R4" : "R3");
        end

        // random bus cycles: decode checks only
        for (int n = 0; n < 300; n++) begin
            logic [2:0] f = 3'($urandom());
            logic [2:0] l = 3'($urandom());
            logic       s = 1'($urandom());
            if ($urandom_range(0, 1) == 0) f = 3'b111;
            @(negedge clk); fc = f; addr_lvl = l; as_n = s; #1;
            check((s == 1'b0 && f == 3'b111 && l != 3'd0) ? "R5" : "R6",
                  32'(iack_n), 32'(exp_iack(s, f, l)));
            if (s) check("R8 random", 32'(dtack_n), 32'd1);
        end
        @(negedge clk); as_n = 1'b1; fc = 3'b101;
        repeat (2) @(posedge clk);

        // directed decode corners
        @(negedge clk); fc = 3'b111; addr_lvl = 3'd0; as_n = 1'b0; #1;
        check("R6 level zero", 32'(iack_n), 32'h7F);
        @(posedge clk); #1;
        check("R6 level zero no answer", 32'(dtack_n), 32'd1);
        @(negedge clk); fc = 3'b110; addr_lvl = 3'd4; #1;
        check("R6 supervisor program", 32'(iack_n), 32'h7F);
        @(negedge clk); as_n = 1'b1; fc = 3'b111; #1;
        check("R6 strobe high", 32'(iack_n), 32'h7F);
        @(posedge clk);

        // full answers for every level
        for (int l = 1; l <= 7; l++) do_ack(3'(l));
        vec_table = {$urandom(), $urandom()};
        do_ack(3'd7);
        do_ack(3'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule